// File: doc/BRIEF.md
# Circuit-Setup Probe Routing Controller

This block is the per-router controller that steers circuit-setup probes through a two-dimensional network. Each neighbour link carries a single-flit control channel paired with a physical data channel. A probe arrives on one port and takes one of four actions. It may claim a free output pair and move one hop closer to its destination. It may take a detour hop, within a fixed limit on how many detours a probe may make. It may turn round and retreat toward the port it came from. If it has reached its destination, it is handed to the local port.

For every input, the controller keeps a record of which outputs a probe has already tried at this router. A retreating probe therefore never searches the same link twice. The controller also holds the forward mapping from each input to the output it claimed and the reverse mapping from each output back to its input. Setup acknowledgments climb back along the reverse mapping, and teardown flits walk forward along the forward mapping. Each teardown releases the channel pairs it passes through.

One probe is serviced per cycle, chosen from all ports. Acknowledgments and teardowns are handled on every port in parallel. The outputs are a registered probe flit with a one-hot port valid, acknowledgment pulses, teardown pulses, and a per-output view of the busy and acknowledged flags.

Top module: `probe_route_ctl`

## Requirements
- R1: After reset, every output channel reads free (chan_busy = 0), no acknowledged flag is set, and no probe, acknowledgment or teardown output is valid.
- R2: A probe flit is 15 bits: bit 14 marks a probe, bit 13 means retreating, bit 12 is the force flag, bits 11:10 are the detour count, bits 9:5 the dimension-1 offset and bits 4:0 the dimension-0 offset, both two's complement. Ports 0/1 are dimension 0 plus/minus, ports 2/3 dimension 1 plus/minus, and port 4 is local. A hop out of a plus port decrements that dimension's offset, and a hop out of a minus port increments it. Among the hops that shrink an offset, the lowest port number is taken.
- R3: An output is claimed only if both its control channel (chan_busy) and its physical channel (phys_busy) are free in the deciding cycle. The probe leaves on that port, and chan_busy rises, one cycle after it was offered.
- R4: A detour hop is taken only when no offset-shrinking output is available and the detour count is below MAX_MIS (2). The lowest free port is chosen, never the port the probe arrived on, and the count is incremented by one.
- R5: When no output is allowed and the force flag is clear, the probe is sent back out of the port it arrived on with bit 13 set and its offsets and count unchanged, and the search history for that input is cleared.
- R6: A retreating probe arriving on a claimed output frees that output and restores its offsets, reducing the count if that hop was a detour. The search then resumes from the original input while skipping every output already recorded in that input's history.
- R7: A probe with both offsets zero is delivered on the local port unchanged, and an acknowledgment pulse is issued on the port it arrived on in the same cycle.
- R8: An acknowledgment arriving on a claimed output sets that output's acknowledged flag and produces an acknowledgment pulse on the mapped input one cycle later.
- R9: A teardown arriving on a mapped input frees the mapped output, clears its acknowledged flag and the input's history, and produces a teardown pulse on that output one cycle later. A teardown on an unmapped input produces no teardown pulse.
- R10: A probe with the force flag set that finds no allowed output is not granted. It produces no output and changes no channel state, and it is granted once an output is released.
- R11: When several ports offer probes, only the lowest-numbered one is granted. A flit whose bit 14 is clear is never granted and produces no output.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| in_vld | input | 5 | Probe flit offered on each port |
| in_flit | input | 5x15 | Probe flit per port |
| probe_gnt | output | 5 | One-hot: the offered probe consumed this cycle |
| phys_busy | input | 4 | Physical channel of each output already in use |
| out_vld | output | 5 | One-hot: port on which out_flit leaves |
| out_flit | output | 15 | Outgoing probe flit |
| ack_in | input | 4 | Setup acknowledgment arriving on each output |
| ack_out | output | 5 | Setup acknowledgment sent back on each input |
| tear_in | input | 5 | Teardown arriving on each input |
| tear_out | output | 4 | Teardown forwarded on each output |
| chan_busy | output | 4 | Output control/physical pair claimed |
| ack_ret | output | 4 | Setup acknowledgment has passed through the output |

## Verification
The hardest state to reach is a retreat that reopens the search at a router. It needs a claimed output, a retreating flit carrying the offsets the downstream neighbour would hold, and history bits that must exclude exactly the outputs already tried. The bench builds this step by step. It sends a probe out, returns it retreating twice so that it detours onto successively higher ports, and then blocks the last physical channel so that the third retreat falls through to the source. The history exclusion is then visible in the chosen port and in the restored detour count.

// File: rtl/probe_pkg.sv
package probe_pkg;
  localparam int NDIM   = 2;
  localparam int OFS_W  = 5;
  localparam int MIS_W  = 2;
  localparam int NDIR   = 2 * NDIM;
  localparam int NPORT  = NDIR + 1;
  localparam int LOCAL  = NDIR;
  localparam int PORT_W = $clog2(NPORT);
  localparam int DIR_W  = $clog2(NDIR);

  typedef struct packed {
    logic                       hdr;
    logic                       bk;
    logic                       force_rel;
    logic [MIS_W-1:0]           mis;
    logic [NDIM-1:0][OFS_W-1:0] off;
  } flit_t;

  localparam int FLIT_W = $bits(flit_t);

  // outputs whose hop shrinks an offset: even = plus side, odd = minus side
  function automatic logic [NDIR-1:0] gain_mask(flit_t f);
    logic [NDIR-1:0] m;
    m = '0;
    for (int d = 0; d < NDIM; d++) begin
      if ($signed(f.off[d]) > 0)      m[2*d]   = 1'b1;
      else if ($signed(f.off[d]) < 0) m[2*d+1] = 1'b1;
    end
    return m;
  endfunction

  // move across one hop on output o; undo=1 reverses the move
  function automatic flit_t hop(flit_t f, logic [DIR_W-1:0] o, logic undo);
    flit_t r;
    int    d;
    r = f;
    d = int'(o) >> 1;
    if (o[0] == undo) r.off[d] = f.off[d] - 1'b1;
    else              r.off[d] = f.off[d] + 1'b1;
    return r;
  endfunction

  function automatic logic at_dest(flit_t f);
    logic z;
    z = 1'b1;
    for (int d = 0; d < NDIM; d++) if (f.off[d] != '0) z = 1'b0;
    return z;
  endfunction

  function automatic logic [DIR_W-1:0] lowest(logic [NDIR-1:0] m);
    logic [DIR_W-1:0] r;
    r = '0;
    for (int i = NDIR - 1; i >= 0; i--) if (m[i]) r = DIR_W'(i);
    return r;
  endfunction
endpackage

// File: rtl/probe_arb.sv
module probe_arb #(
  parameter int N = 5
) (
  input  logic [N-1:0]         req,
  output logic [N-1:0]         gnt,
  output logic [$clog2(N)-1:0] idx,
  output logic                 any
);
  logic [N:0] seen;
  assign seen[0] = 1'b0;
  for (genvar i = 0; i < N; i++) begin : g_pri
    assign gnt[i]    = req[i] & ~seen[i];
    assign seen[i+1] = seen[i] | req[i];
  end
  assign any = seen[N];

  always_comb begin
    idx = '0;
    for (int i = N - 1; i >= 0; i--) if (req[i]) idx = ($clog2(N))'(i);
  end
endmodule

// File: rtl/probe_route_sel.sv
module probe_route_sel
  import probe_pkg::*;
#(
  parameter int MAX_MIS = 2
) (
  input  flit_t            f,
  input  logic [NDIR-1:0]  avail,
  output logic             found,
  output logic [DIR_W-1:0] dir,
  output logic             detour,
  output flit_t            fout
);
  logic [NDIR-1:0] gain, cand_g, cand_d;
  logic            may_detour;

  assign gain       = gain_mask(f);
  assign cand_g     = avail & gain;
  assign cand_d     = avail & ~gain;
  assign may_detour = (int'(f.mis) < MAX_MIS);

  always_comb begin
    found  = 1'b0;
    detour = 1'b0;
    dir    = '0;
    if (cand_g != '0) begin
      found = 1'b1;
      dir   = lowest(cand_g);
    end else if (may_detour && cand_d != '0) begin
      found  = 1'b1;
      detour = 1'b1;
      dir    = lowest(cand_d);
    end
    fout    = hop(f, dir, 1'b0);
    fout.bk = 1'b0;
    if (detour) fout.mis = f.mis + 1'b1;
  end
endmodule

// File: rtl/probe_route_ctl.sv
module probe_route_ctl
  import probe_pkg::*;
#(
  parameter int MAX_MIS = 2
) (
  input  logic                          clk,
  input  logic                          rst_n,
  input  logic [NPORT-1:0]              in_vld,
  input  logic [NPORT-1:0][FLIT_W-1:0]  in_flit,
  output logic [NPORT-1:0]              probe_gnt,
  input  logic [NDIR-1:0]               phys_busy,
  output logic [NPORT-1:0]              out_vld,
  output logic [FLIT_W-1:0]             out_flit,
  input  logic [NDIR-1:0]               ack_in,
  output logic [NPORT-1:0]              ack_out,
  input  logic [NPORT-1:0]              tear_in,
  output logic [NDIR-1:0]               tear_out,
  output logic [NDIR-1:0]               chan_busy,
  output logic [NDIR-1:0]               ack_ret
);
  // channel and mapping state
  logic [NDIR-1:0]              busy_q, busy_n, ackr_q, ackr_n;
  logic [NPORT-1:0]             fvld_q, fvld_n;
  logic [NPORT-1:0][DIR_W-1:0]  fmap_q, fmap_n;
  logic [NDIR-1:0]              rvld_q, rvld_n;
  logic [NDIR-1:0][PORT_W-1:0]  rmap_q, rmap_n;
  logic [NPORT-1:0][NDIR-1:0]   hist_q, hist_n;
  logic [NPORT-1:0]             ovld_q, ovld_n, aout_q, aout_n;
  logic [FLIT_W-1:0]            oflit_q, oflit_n;
  logic [NDIR-1:0]              tout_q, tout_n;

  // named events
  logic [NPORT-1:0]  req, arb_gnt;
  logic [PORT_W-1:0] sel, anchor;
  logic              any, bk_ok, deliver, act, stall_ev;
  logic [DIR_W-1:0]  back_dir, dir;
  logic              found, detour;
  flit_t             f_in, f_rest, f_out, f_back;
  logic [NDIR-1:0]   avail, back_excl;

  for (genvar p = 0; p < NPORT; p++) begin : g_req
    assign req[p] = in_vld[p] & in_flit[p][FLIT_W-1];
  end

  probe_arb #(.N(NPORT)) u_arb (
    .req (req),
    .gnt (arb_gnt),
    .idx (sel),
    .any (any)
  );

  assign f_in     = flit_t'(in_flit[sel]);
  assign back_dir = sel[DIR_W-1:0];
  assign bk_ok    = any && f_in.bk && (int'(sel) < LOCAL) && rvld_q[back_dir];
  assign anchor   = bk_ok ? rmap_q[back_dir] : sel;
  assign deliver  = any && !f_in.bk && at_dest(f_in);
  assign act      = (any && !f_in.bk) || bk_ok;

  // restore the view this router had before the hop that is being retreated
  always_comb begin
    f_rest = f_in;
    if (bk_ok) begin
      f_rest    = hop(f_in, back_dir, 1'b1);
      f_rest.bk = 1'b0;
      if (!gain_mask(f_rest)[back_dir]) f_rest.mis = f_in.mis - 1'b1;
    end
    f_back    = f_rest;
    f_back.bk = 1'b1;
  end

  always_comb begin
    back_excl = '0;
    if (int'(anchor) < LOCAL) back_excl[anchor[DIR_W-1:0]] = 1'b1;
  end

  assign avail = ~busy_q & ~phys_busy & ~hist_q[anchor] & ~back_excl;

  probe_route_sel #(.MAX_MIS(MAX_MIS)) u_sel (
    .f      (f_rest),
    .avail  (avail),
    .found  (found),
    .dir    (dir),
    .detour (detour),
    .fout   (f_out)
  );

  assign stall_ev  = act && !deliver && !found && f_rest.force_rel;
  assign probe_gnt = arb_gnt & {NPORT{~stall_ev}};

  always_comb begin
    busy_n  = busy_q;
    ackr_n  = ackr_q;
    fvld_n  = fvld_q;
    fmap_n  = fmap_q;
    rvld_n  = rvld_q;
    rmap_n  = rmap_q;
    hist_n  = hist_q;
    ovld_n  = '0;
    oflit_n = '0;
    aout_n  = '0;
    tout_n  = '0;

    // acknowledgments climb the reverse mapping
    for (int o = 0; o < NDIR; o++) begin
      if (ack_in[o] && busy_q[o] && rvld_q[o]) begin
        ackr_n[o]         = 1'b1;
        aout_n[rmap_q[o]] = 1'b1;
      end
    end

    // the one probe serviced this cycle
    if (any && !stall_ev) begin
      if (deliver) begin
        ovld_n[LOCAL] = 1'b1;
        oflit_n       = f_in;
        aout_n[sel]   = 1'b1;
      end else if (act) begin
        if (bk_ok) begin
          busy_n[back_dir] = 1'b0;
          ackr_n[back_dir] = 1'b0;
          rvld_n[back_dir] = 1'b0;
          fvld_n[anchor]   = 1'b0;
        end
        if (found) begin
          busy_n[dir]         = 1'b1;
          fvld_n[anchor]      = 1'b1;
          fmap_n[anchor]      = dir;
          rvld_n[dir]         = 1'b1;
          rmap_n[dir]         = anchor;
          hist_n[anchor][dir] = 1'b1;
          ovld_n[dir]         = 1'b1;
          oflit_n             = f_out;
        end else begin
          ovld_n[anchor] = 1'b1;
          oflit_n        = f_back;
          hist_n[anchor] = '0;
        end
      end
    end

    // teardowns walk the forward mapping and take precedence
    for (int i = 0; i < NPORT; i++) begin
      if (tear_in[i]) begin
        hist_n[i] = '0;
        if (fvld_q[i]) begin
          busy_n[fmap_q[i]] = 1'b0;
          ackr_n[fmap_q[i]] = 1'b0;
          rvld_n[fmap_q[i]] = 1'b0;
          tout_n[fmap_q[i]] = 1'b1;
          fvld_n[i]         = 1'b0;
        end
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy_q  <= '0;
      ackr_q  <= '0;
      fvld_q  <= '0;
      fmap_q  <= '0;
      rvld_q  <= '0;
      rmap_q  <= '0;
      hist_q  <= '0;
      ovld_q  <= '0;
      oflit_q <= '0;
      aout_q  <= '0;
      tout_q  <= '0;
    end else begin
      busy_q  <= busy_n;
      ackr_q  <= ackr_n;
      fvld_q  <= fvld_n;
      fmap_q  <= fmap_n;
      rvld_q  <= rvld_n;
      rmap_q  <= rmap_n;
      hist_q  <= hist_n;
      ovld_q  <= ovld_n;
      oflit_q <= oflit_n;
      aout_q  <= aout_n;
      tout_q  <= tout_n;
    end
  end

  assign out_vld   = ovld_q;
  assign out_flit  = oflit_q;
  assign ack_out   = aout_q;
  assign tear_out  = tout_q;
  assign chan_busy = busy_q;
  assign ack_ret   = ackr_q;
endmodule

// File: rtl/probe_route_chk.sv
module probe_route_chk
  import probe_pkg::*;
#(
  parameter int MAX_MIS = 2
) (
  input logic                 clk,
  input logic                 rst_n,
  input logic [NPORT-1:0]     probe_gnt,
  input logic [NPORT-1:0]     out_vld,
  input logic [FLIT_W-1:0]    out_flit,
  input logic [NDIR-1:0]      phys_busy,
  input logic [NDIR-1:0]      ack_in,
  input logic [NDIR-1:0]      tear_out,
  input logic [NDIR-1:0]      chan_busy,
  input logic [NDIR-1:0]      ack_ret
);
  flit_t of;
  assign of = flit_t'(out_flit);

  // R11
  gnt_onehot_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(probe_gnt));

  // R11
  out_onehot_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(out_vld));

  // R4
  mis_limit_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ((out_vld != '0) && !of.bk) |-> (int'(of.mis) <= MAX_MIS));

  for (genvar o = 0; o < NDIR; o++) begin : g_dir
    // R3
    claim_pair_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (out_vld[o] && !of.bk) |-> (chan_busy[o] && !$past(phys_busy[o])));

    // R9
    tear_free_chk: assert property (@(posedge clk) disable iff (!rst_n)
      tear_out[o] |-> (!chan_busy[o] && !ack_ret[o]));

    // R8
    ack_flag_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (ack_in[o] && chan_busy[o]) |=> (ack_ret[o] || tear_out[o]));

    // R1
    ack_sub_chk: assert property (@(posedge clk) disable iff (!rst_n)
      ack_ret[o] |-> chan_busy[o]);
  end
endmodule

bind probe_route_ctl probe_route_chk #(.MAX_MIS(MAX_MIS)) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .probe_gnt (probe_gnt),
  .out_vld   (out_vld),
  .out_flit  (out_flit),
  .phys_busy (phys_busy),
  .ack_in    (ack_in),
  .tear_out  (tear_out),
  .chan_busy (chan_busy),
  .ack_ret   (ack_ret)
);

// File: tb/probe_route_ctl_bench.sv
`timescale 1ns/1ps
module probe_route_ctl_bench;
  logic             clk = 1'b0;
  logic             rst_n = 1'b0;
  logic [4:0]       in_vld = '0;
  logic [4:0][14:0] in_flit = '0;
  logic [4:0]       probe_gnt;
  logic [3:0]       phys_busy = '0;
  logic [4:0]       out_vld;
  logic [14:0]      out_flit;
  logic [3:0]       ack_in = '0;
  logic [4:0]       ack_out;
  logic [4:0]       tear_in = '0;
  logic [3:0]       tear_out;
  logic [3:0]       chan_busy;
  logic [3:0]       ack_ret;

  int n_chk = 0;
  int n_bad = 0;
  bit done  = 0;

  always #2.5 clk = ~clk;

  probe_route_ctl #(.MAX_MIS(2)) u_probe_route_ctl (
    .clk(clk), .rst_n(rst_n), .in_vld(in_vld), .in_flit(in_flit),
    .probe_gnt(probe_gnt), .phys_busy(phys_busy), .out_vld(out_vld),
    .out_flit(out_flit), .ack_in(ack_in), .ack_out(ack_out),
    .tear_in(tear_in), .tear_out(tear_out), .chan_busy(chan_busy),
    .ack_ret(ack_ret)
  );

  // probe flit: {probe, retreat, force, count[1:0], off1[4:0], off0[4:0]}
  function automatic logic [14:0] mk(bit bk, bit frc, int mis, int o1, int o0);
    logic [1:0] m;
    logic [4:0] a, b;
    m = mis[1:0];
    a = o1[4:0];
    b = o0[4:0];
    return {1'b1, bk, frc, m, a, b};
  endfunction

  typedef struct packed {
    logic [2:0]  port;
    logic [14:0] flit;
    logic [3:0]  pb;
    logic [4:0]  gnt;
    logic [4:0]  om;
    logic [14:0] of;
    logic [4:0]  am;
    logic [3:0]  busy;
  } row_t;

  localparam int NROW = 9;
  localparam row_t TAB [NROW] = '{
    '{3'd4, mk(0,0,0, 0, 3), 4'b0000, 5'b10000, 5'b00001, mk(0,0,0, 0, 2), 5'b00000, 4'b0001},
    '{3'd4, mk(0,0,0, 1,-2), 4'b0000, 5'b10000, 5'b00010, mk(0,0,0, 1,-1), 5'b00000, 4'b0010},
    '{3'd4, mk(0,0,0, 0, 1), 4'b0001, 5'b10000, 5'b00010, mk(0,0,1, 0, 2), 5'b00000, 4'b0010},
    '{3'd0, mk(0,0,0, 0,-1), 4'b0000, 5'b00001, 5'b00010, mk(0,0,0, 0, 0), 5'b00000, 4'b0010},
    '{3'd2, mk(0,0,1, 0, 0), 4'b0000, 5'b00100, 5'b10000, mk(0,0,1, 0, 0), 5'b00100, 4'b0000},
    '{3'd4, mk(0,0,2, 0, 1), 4'b0001, 5'b10000, 5'b10000, mk(1,0,2, 0, 1), 5'b00000, 4'b0000},
    '{3'd1, 15'h0021,        4'b0000, 5'b00000, 5'b00000, 15'h0000,        5'b00000, 4'b0000},
    '{3'd3, mk(0,0,1, 2, 0), 4'b0100, 5'b01000, 5'b00001, mk(0,0,2, 2,-1), 5'b00000, 4'b0001},
    '{3'd4, mk(0,1,2, 0, 1), 4'b0001, 5'b00000, 5'b00000, 15'h0000,        5'b00000, 4'b0000}
  };
  localparam string RTAG [NROW] = '{"R2", "R2", "R4", "R4", "R7", "R5", "R11", "R4", "R10"};

  logic [4:0]  s_gnt, s_om, s_am;
  logic [14:0] s_of;
  logic [3:0]  s_busy, s_ackr, s_tout;

  task automatic check(string tag, string what, logic [31:0] act, logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s %s: actual %0h expected %0h", tag, what, act, exp);
    end
  endtask

  task automatic do_reset();
    in_vld = '0; in_flit = '0; phys_busy = '0; ack_in = '0; tear_in = '0;
    rst_n = 1'b0;
    repeat (2) @(negedge clk);
    rst_n = 1'b1;
  endtask

  // drive at the falling edge, read the grant before the rising edge,
  // read registered results just after it
  task automatic cycle();
    #1 s_gnt = probe_gnt;
    @(posedge clk);
    #1;
    s_om = out_vld; s_of = out_flit; s_am = ack_out;
    s_busy = chan_busy; s_ackr = ack_ret; s_tout = tear_out;
    in_vld = '0; in_flit = '0; phys_busy = '0; ack_in = '0; tear_in = '0;
  endtask

  task automatic send(int port, logic [14:0] f, logic [3:0] pb);
    @(negedge clk);
    in_vld[port]  = 1'b1;
    in_flit[port] = f;
    phys_busy     = pb;
    cycle();
  endtask

  initial begin
    do_reset();
    @(negedge clk);
    // R1: reset state
    check("R1", "chan_busy", 32'(chan_busy), 0);
    check("R1", "ack_ret", 32'(ack_ret), 0);
    check("R1", "out_vld", 32'(out_vld), 0);
    check("R1", "ack_out", 32'(ack_out), 0);
    check("R1", "tear_out", 32'(tear_out), 0);

    // table of single-probe cases, each from a fresh reset
    for (int k = 0; k < NROW; k++) begin
      do_reset();
      send(int'(TAB[k].port), TAB[k].flit, TAB[k].pb);
      check(RTAG[k], "grant", 32'(s_gnt), 32'(TAB[k].gnt));
      check(RTAG[k], "out_vld", 32'(s_om), 32'(TAB[k].om));
      if (TAB[k].om != '0) check(RTAG[k], "out_flit", 32'(s_of), 32'(TAB[k].of));
      check(RTAG[k], "ack_out", 32'(s_am), 32'(TAB[k].am));
      check("R3", "chan_busy", 32'(s_busy), 32'(TAB[k].busy));
    end

    // R6: retreat, history exclusion and count restore
    do_reset();
    send(4, mk(0,0,0, 0, 2), 4'b0000);
    check("R2", "first hop port", 32'(s_om), 32'b00001);
    send(0, mk(1,0,0, 0, 1), 4'b0000);
    check("R6", "retry port after first retreat", 32'(s_om), 32'b00010);
    check("R6", "retry flit", 32'(s_of), 32'(mk(0,0,1, 0, 3)));
    check("R6", "busy after first retreat", 32'(s_busy), 32'b0010);
    send(1, mk(1,0,1, 0, 3), 4'b0000);
    check("R6", "retry port after second retreat", 32'(s_om), 32'b00100);
    check("R6", "second retry flit", 32'(s_of), 32'(mk(0,0,1,-1, 2)));
    check("R6", "busy after second retreat", 32'(s_busy), 32'b0100);
    send(2, mk(1,0,1,-1, 2), 4'b1000);
    check("R5", "retreat to source port", 32'(s_om), 32'b10000);
    check("R5", "retreat flit", 32'(s_of), 32'(mk(1,0,0, 0, 2)));
    check("R6", "all released", 32'(s_busy), 32'b0000);
    // history for the source was cleared: the plus hop is taken again
    send(4, mk(0,0,0, 0, 2), 4'b0000);
    check("R5", "history cleared after retreat", 32'(s_om), 32'b00001);

    // R8 / R9: acknowledgment and teardown
    do_reset();
    send(1, mk(0,0,0, 1, 0), 4'b0000);
    check("R2", "hop on dimension 1 plus", 32'(s_om), 32'b00100);
    @(negedge clk); ack_in = 4'b0100; cycle();
    check("R8", "ack_out on mapped input", 32'(s_am), 32'b00010);
    check("R8", "ack_ret flag", 32'(s_ackr), 32'b0100);
    @(negedge clk); tear_in = 5'b00010; cycle();
    check("R9", "tear_out on mapped output", 32'(s_tout), 32'b0100);
    check("R9", "busy released", 32'(s_busy), 32'b0000);
    check("R9", "ack_ret cleared", 32'(s_ackr), 32'b0000);
    send(1, mk(0,0,0, 1, 0), 4'b0000);
    check("R9", "same output reusable", 32'(s_om), 32'b00100);
    @(negedge clk); tear_in = 5'b01000; cycle();
    check("R9", "unmapped teardown silent", 32'(s_tout), 32'b0000);
    check("R9", "unmapped teardown keeps claim", 32'(s_busy), 32'b0100);

    // R10: forced probe waits, then proceeds once released
    do_reset();
    send(4, mk(0,0,0, 0, 1), 4'b0000);
    check("R3", "claim port 0", 32'(s_busy), 32'b0001);
    send(1, mk(0,1,2, 0, 1), 4'b0000);
    check("R10", "forced probe not granted", 32'(s_gnt), 32'b00000);
    check("R10", "forced probe no output", 32'(s_om), 32'b00000);
    check("R10", "forced probe keeps state", 32'(s_busy), 32'b0001);
    @(negedge clk); tear_in = 5'b10000; cycle();
    send(1, mk(0,1,2, 0, 1), 4'b0000);
    check("R10", "forced probe granted later", 32'(s_gnt), 32'b00010);
    check("R10", "forced probe out port", 32'(s_om), 32'b00001);
    check("R10", "forced probe flit", 32'(s_of), 32'(mk(0,1,2, 0, 0)));

    // R11: two ports at once, lowest wins
    do_reset();
    @(negedge clk);
    in_vld = 5'b01010;
    in_flit[1] = mk(0,0,0, 0, 0);
    in_flit[3] = mk(0,0,0, 0, 0);
    cycle();
    check("R11", "lowest port granted", 32'(s_gnt), 32'b00010);
    check("R11", "only winner acknowledged", 32'(s_am), 32'b00010);
    check("R7", "delivered locally", 32'(s_om), 32'b10000);

    done = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      n_chk++;
      n_bad++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end
endmodule